// File: doc/BRIEF.md
# Upset-Tolerant Parallel Bus Receive Register

This block sits at the receiving end of a clocked parallel data bus, 32 bits wide by default, that can suffer single-event upsets. It uses time redundancy. The sender holds every word on the bus for three consecutive clock cycles. The receiver captures the bus once per cycle into three separate capture registers. Once the third copy is in, the copies are compared.

When every copy matches bit for bit, the word is loaded in parallel into the output register and a one-cycle valid pulse is given. When any bit of any copy differs, the output register keeps the last word that was received correctly, and a one-cycle resend request is raised instead. The sender reacts to the resend request by sending the word again in a later three-cycle slot. That retransmission protocol belongs to the sender and is outside this block.

The capture sequence runs freely in slots of three cycles, starting at the first clock edge after reset is released. A rejection does not disturb the slot alignment, so a word sent again in the next slot is captured cleanly.

Top module: `seu_rx_reg`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs after that edge are `data_o` = 0, `valid_o` = 0 and `resend_o` = 0.
- R2: The bus is sampled once per cycle. Slot k covers the rising edges 3k, 3k+1 and 3k+2, counted from the first edge after reset is released. The sender holds each word stable for the three edges of its slot.
- R3: When all three samples of a slot are equal, `data_o` takes that word at edge 3k+3 and `valid_o` is high for exactly the cycle that follows that edge.
- R4: When any bit differs between the samples of a slot (a single-bit or multi-bit flip in any one sample), `data_o` keeps its previous value and `resend_o` is high for exactly the cycle that follows edge 3k+3.
- R5: `valid_o` and `resend_o` are never high together. Each rises only on a decision cycle, which comes once every three cycles.
- R6: A rejection leaves the slot alignment unchanged, so a clean word sent in the slot after a rejected one is accepted.
- R7: `data_o` changes only in a cycle where `valid_o` is high.
- R8: After several rejected slots in a row, `data_o` still holds the last accepted word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_i | input | WIDTH | Incoming bus data, held for three cycles per word |
| data_o | output | WIDTH | Last correctly received word |
| valid_o | output | 1 | One-cycle pulse when a word is accepted |
| resend_o | output | 1 | One-cycle pulse when a word is rejected |

## Verification
The assertions assume the sender keeps to the slot framing. Every word, corrupted or not, occupies exactly three cycles that are aligned to the edges after reset, so a decision falls every third cycle. The bench's single send task always drives three consecutive cycles per word, and it injects upsets only as XOR masks on one of those three cycles. Framing is therefore never broken, and only the sample contents vary.

// File: rtl/seu_rx_pkg.sv
package seu_rx_pkg;

    localparam int DEF_WIDTH  = 32;
    localparam int DEF_COPIES = 3;

    function automatic int phase_bits(input int copies);
        return (copies > 1) ? $clog2(copies) : 1;
    endfunction

endpackage

// File: rtl/seu_rx_phase_ctr.sv
module seu_rx_phase_ctr
    import seu_rx_pkg::*;
#(
    parameter int COPIES = DEF_COPIES,
    localparam int PW    = phase_bits(COPIES)
) (
    input  logic          clk,
    input  logic          rst,
    output logic [PW-1:0] phase_o,
    output logic          last_o
);
    localparam logic [PW-1:0] LAST = PW'(COPIES - 1);

    logic [PW-1:0] phase_d, phase_q;

    always_comb begin
        phase_d = phase_q + PW'(1);
        if (phase_q == LAST) begin
            phase_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_d;
        end
    end

    assign phase_o = phase_q;
    assign last_o  = (phase_q == LAST);
endmodule

// File: rtl/seu_rx_capture_bank.sv
module seu_rx_capture_bank
    import seu_rx_pkg::*;
#(
    parameter int WIDTH  = DEF_WIDTH,
    parameter int COPIES = DEF_COPIES,
    localparam int PW    = phase_bits(COPIES)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [PW-1:0]                phase_i,
    input  logic [WIDTH-1:0]             bus_i,
    output logic [COPIES-1:0][WIDTH-1:0] copies_o
);
    for (genvar g = 0; g < COPIES; g++) begin : g_copy
        logic [WIDTH-1:0] cap_d, cap_q;

        always_comb begin
            cap_d = cap_q;
            if (phase_i == PW'(g)) begin
                cap_d = bus_i;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                cap_q <= '0;
            end else begin
                cap_q <= cap_d;
            end
        end

        assign copies_o[g] = cap_q;
    end
endmodule

// File: rtl/seu_rx_agree.sv
module seu_rx_agree
    import seu_rx_pkg::*;
#(
    parameter int WIDTH  = DEF_WIDTH,
    parameter int COPIES = DEF_COPIES
) (
    input  logic [COPIES-1:0][WIDTH-1:0] copies_i,
    output logic                         mismatch_o
);
    logic [WIDTH-1:0] diff;

    always_comb begin
        diff = '0;
        for (int i = 1; i < COPIES; i++) begin
            diff = diff | (copies_i[i] ^ copies_i[0]);
        end
        mismatch_o = |diff;
    end
endmodule

// File: rtl/seu_rx_reg.sv
module seu_rx_reg
    import seu_rx_pkg::*;
#(
    parameter int WIDTH  = DEF_WIDTH,
    parameter int COPIES = DEF_COPIES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] bus_i,
    output logic [WIDTH-1:0] data_o,
    output logic             valid_o,
    output logic             resend_o
);
    localparam int PW = phase_bits(COPIES);

    typedef struct packed {
        logic [WIDTH-1:0] data;
        logic             valid;
        logic             resend;
        logic             pend;
    } state_t;

    state_t                      st_d, st_q;
    logic [PW-1:0]               phase;
    logic                        last_phase;
    logic [COPIES-1:0][WIDTH-1:0] copies;
    logic                        mismatch;

    seu_rx_phase_ctr #(.COPIES(COPIES)) u_phase (
        .clk     (clk),
        .rst     (rst),
        .phase_o (phase),
        .last_o  (last_phase)
    );

    seu_rx_capture_bank #(.WIDTH(WIDTH), .COPIES(COPIES)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .phase_i  (phase),
        .bus_i    (bus_i),
        .copies_o (copies)
    );

    seu_rx_agree #(.WIDTH(WIDTH), .COPIES(COPIES)) u_agree (
        .copies_i   (copies),
        .mismatch_o (mismatch)
    );

    always_comb begin
        st_d        = st_q;
        st_d.valid  = 1'b0;
        st_d.resend = 1'b0;
        st_d.pend   = last_phase;
        if (st_q.pend) begin
            if (mismatch) begin
                st_d.resend = 1'b1;
            end else begin
                st_d.data  = copies[0];
                st_d.valid = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign data_o   = st_q.data;
    assign valid_o  = st_q.valid;
    assign resend_o = st_q.resend;
endmodule

// File: rtl/seu_rx_reg_chk.sv
module seu_rx_reg_chk #(
    parameter int WIDTH  = 32,
    parameter int COPIES = 3
) (
    input logic             clk,
    input logic             rst,
    input logic [WIDTH-1:0] data_o,
    input logic             valid_o,
    input logic             resend_o
);
    logic        seen_q;
    logic [15:0] gap_q;
    logic        pulse;

    assign pulse = valid_o | resend_o;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q <= 1'b0;
            gap_q  <= '0;
        end else if (pulse) begin
            seen_q <= 1'b1;
            gap_q  <= '0;
        end else begin
            gap_q  <= gap_q + 16'd1;
        end
    end

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (data_o == '0 && !valid_o && !resend_o));

    // R5
    no_both_pulses_chk: assert property (@(posedge clk) disable iff (rst)
        !(valid_o && resend_o));

    // R3
    valid_single_chk: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);

    // R4
    resend_single_chk: assert property (@(posedge clk) disable iff (rst)
        resend_o |=> !resend_o);

    // R2
    decision_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        (pulse && seen_q) |-> (gap_q == 16'(COPIES - 1)));

    // R7
    data_only_on_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (data_o != $past(data_o)) |-> valid_o);
endmodule

bind seu_rx_reg seu_rx_reg_chk #(.WIDTH(WIDTH), .COPIES(COPIES)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .data_o   (data_o),
    .valid_o  (valid_o),
    .resend_o (resend_o)
);

// File: tb/seu_rx_reg_bench.sv
module seu_rx_reg_bench;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] bus = '0;
    logic [W-1:0] data_o;
    logic         valid_o, resend_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [W-1:0] last_good = '0;
    logic [W-1:0] prev_word = '0;
    bit           have_prev = 1'b0;
    bit           prev_bad  = 1'b0;

    always #2 clk = ~clk;

    seu_rx_reg #(.WIDTH(W), .COPIES(3)) u_seu_rx_reg (
        .clk(clk), .rst(rst), .bus_i(bus),
        .data_o(data_o), .valid_o(valid_o), .resend_o(resend_o)
    );

    task automatic check(input string req, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drives one three-cycle slot; checks the decision of the previous slot.
    task automatic send_word(input logic [W-1:0] w, input logic [W-1:0] mask,
                             input int flip_ph);
        for (int p = 0; p < 3; p++) begin
            bus = (p == flip_ph) ? (w ^ mask) : w;
            @(posedge clk);
            @(negedge clk);
            if (p == 0 && have_prev) begin
                if (prev_bad) begin
                    check("R4 resend on upset", W'(resend_o), W'(1));
                    check("R4 valid low on upset", W'(valid_o), W'(0));
                    check("R8 data holds last good", data_o, last_good);
                end else begin
                    check("R3 valid on clean word", W'(valid_o), W'(1));
                    check("R6 resend low on clean word", W'(resend_o), W'(0));
                    check("R3 data loads word", data_o, prev_word);
                end
            end
            if (p == 1 && have_prev) begin
                check("R5 pulses last one cycle", W'({valid_o, resend_o}), W'(0));
            end
        end
        if (have_prev && !prev_bad) last_good = prev_word;
        have_prev = 1'b1;
        prev_word = w;
        prev_bad  = (mask != '0);
    endtask

    task automatic test_reset();
        @(negedge clk);
        check("R1 data zero after reset", data_o, '0);
        check("R1 valid low after reset", W'(valid_o), W'(0));
        check("R1 resend low after reset", W'(resend_o), W'(0));
        rst = 1'b0;
    endtask

    task automatic test_clean();
        send_word(32'hA5A5_0F0F, '0, 0);
        send_word(32'h1234_5678, '0, 0);
        send_word(32'hFFFF_FFFF, '0, 0);
        send_word(32'h0000_0000, '0, 0);
    endtask

    task automatic test_single_flip();
        for (int ph = 0; ph < 3; ph++) begin
            send_word(32'hDEAD_BEEF, 32'h1 << (ph * 7 + 3), ph);
            send_word(32'hDEAD_BEEF, '0, 0);   // R6 retransmission accepted
        end
    endtask

    task automatic test_multi_flip();
        send_word(32'hCAFE_F00D, 32'h8000_0001, 1);
        send_word(32'h0BAD_CAFE, 32'hFFFF_0000, 2);
        send_word(32'h5555_AAAA, 32'h0F0F_0F0F, 0);
        send_word(32'h5555_AAAA, '0, 0);
    endtask

    task automatic test_flush();
        send_word(32'h7777_1111, '0, 0);
        send_word(32'h0000_0001, '0, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        test_reset();
        test_clean();
        test_single_flip();
        test_multi_flip();
        test_flush();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule